// File: doc/BRIEF.md
# Signed Multiply-Accumulate Register Unit

This unit is the multiply-accumulate datapath of a small processor. It holds a 42-bit signed accumulator. The accumulator is kept as two registers: a 10-bit upper part and a 32-bit lower part. On each accumulate request, the unit multiplies two signed 16-bit operands and adds the sign-extended product into the full accumulator. The sum does not saturate. Carries out of the lower part move into the upper part, and the whole value wraps modulo 2^42.

The host can do four things:
- clear the accumulator;
- load either part from a 32-bit word;
- read either part back as a 32-bit word;
- use the status values the unit reports with each read or load.

When the upper part is read, it is sign-extended to 32 bits. The zero and negative status values describe the whole 42-bit accumulator, not just the part being read. A 4-bit update mask tells the host which of its condition flags to overwrite in that cycle.

Top module: `mac_acc_unit`

## Requirements
- R1: An accumulate request (`acc_i`) adds the signed product of `op_a_i` and `op_b_i` to the accumulator. The new value is visible on `rd_data_o` in the cycle after the request. For example, -2 times 2 from zero reads 0xFFFFFFFC on the lower part.
- R2: Accumulation wraps modulo 2^42. A carry out of the lower 32 bits increments the upper part. Eight products of 0x7FFF times 0x7FFF from zero give upper 0x00000001 and lower 0xFFF80008.
- R3: Loading the upper part (`ld_sel_i`=1) keeps only bits 9:0 of `ld_data_i`. Loading 0xA5A5A5A5 and reading it back gives 0x000001A5.
- R4: Reading the upper part (`rd_sel_i`=1) returns its 10 bits sign-extended from bit 9 to 32 bits.
- R5: The lower part (`ld_sel_i`=0, `rd_sel_i`=0) is loaded and read as an unmodified 32-bit value.
- R6: A clear (`clr_i`) sets both parts to zero. A subsequent read returns 0 with `flag_z_o`=1, `flag_n_o`=0 and `flag_v_o`=0.
- R7: `flag_z_o` is 1 only when all 42 accumulator bits are zero, whichever part is read.
- R8: `flag_n_o` equals accumulator bit 41, whichever part is read.
- R9: `flag_upd_o` bit 0 is zero, bit 1 is negative, bit 2 is overflow and bit 3 is carry.
  - A read (`rd_i`) sets mask 4'b0111.
  - A load without clear sets mask 4'b1100.
  - `flag_v_o` and `flag_c_o` are 0 in both cases.
- R10: When requests are asserted in the same cycle, clear takes priority over load, and load takes priority over accumulate. The lower-priority requests are ignored.
- R11: After reset the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear accumulator |
| ld_i | input | 1 | Load one part from ld_data_i |
| ld_sel_i | input | 1 | Load target: 1 upper, 0 lower |
| ld_data_i | input | 32 | Load word |
| acc_i | input | 1 | Accumulate request |
| op_a_i | input | 16 | Signed operand A |
| op_b_i | input | 16 | Signed operand B |
| rd_i | input | 1 | Read strobe (drives flag mask) |
| rd_sel_i | input | 1 | Read source: 1 upper, 0 lower |
| rd_data_o | output | 32 | Selected part, upper sign-extended |
| flag_z_o | output | 1 | Whole accumulator is zero |
| flag_n_o | output | 1 | Accumulator bit 41 |
| flag_v_o | output | 1 | Overflow value (always cleared) |
| flag_c_o | output | 1 | Carry value (always cleared) |
| flag_upd_o | output | 4 | Flags to update: {c, v, n, z} |

## Verification
The hardest state to reach is a carry crossing from the lower part into the upper part, and in particular one that reaches bit 41 or wraps past it. Products of at most about 2^30 would need thousands of accumulates to get there. The bench instead loads the upper part with 0x1FF or 0x3FF and the lower part with 0xFFFFFFFF, then applies a single 1-times-1 product. That step crosses into the sign bit, or wraps the accumulator to zero, in one cycle. Both halves are then read to confirm the zero and negative flags describe the whole value.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned HI_W  = 10;
  localparam int unsigned LO_W  = 32;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ACC_W = HI_W + LO_W;

  // flag update mask bit positions
  localparam int unsigned FLG_Z = 0;
  localparam int unsigned FLG_N = 1;
  localparam int unsigned FLG_V = 2;
  localparam int unsigned FLG_C = 3;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_CLEAR,
    ACC_LOAD,
    ACC_ADD
  } acc_op_e;
endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned ACC_W = 42
) (
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int unsigned PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] prod;

  always_comb prod = $signed(op_a_i) * $signed(op_b_i);

  generate
    if (ACC_W > PROD_W) begin : g_ext
      assign prod_o = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end else begin : g_trunc
      assign prod_o = prod[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_acc_reg.sv
`timescale 1ns/1ps
module mac_acc_reg
  import mac_pkg::*;
#(
  parameter int unsigned HI_W  = 10,
  parameter int unsigned LO_W  = 32,
  parameter int unsigned BUS_W = 32,
  localparam int unsigned ACC_W = HI_W + LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic             ld_sel_i,
  input  logic [BUS_W-1:0] ld_data_i,
  input  logic             acc_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [HI_W-1:0]  hi_o,
  output logic [LO_W-1:0]  lo_o
);
  acc_op_e          op;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [LO_W-1:0]  lo_q, lo_d;
  logic [ACC_W-1:0] sum;

  // priority: clear > load > accumulate
  always_comb begin
    if (clr_i)      op = ACC_CLEAR;
    else if (ld_i)  op = ACC_LOAD;
    else if (acc_i) op = ACC_ADD;
    else            op = ACC_HOLD;
  end

  assign sum = {hi_q, lo_q} + prod_i;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    unique case (op)
      ACC_CLEAR: begin
        hi_d = '0;
        lo_d = '0;
      end
      ACC_LOAD: begin
        if (ld_sel_i) hi_d = ld_data_i[HI_W-1:0];
        else          lo_d = ld_data_i[LO_W-1:0];
      end
      ACC_ADD: {hi_d, lo_d} = sum;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/mac_rd_flags.sv
`timescale 1ns/1ps
module mac_rd_flags
  import mac_pkg::*;
#(
  parameter int unsigned HI_W  = 10,
  parameter int unsigned LO_W  = 32,
  parameter int unsigned BUS_W = 32
) (
  input  logic [HI_W-1:0]  hi_i,
  input  logic [LO_W-1:0]  lo_i,
  input  logic             rd_i,
  input  logic             rd_sel_i,
  input  logic             ld_i,
  input  logic             clr_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_v_o,
  output logic             flag_c_o,
  output logic [3:0]       flag_upd_o
);
  logic [BUS_W-1:0] hi_ext;

  assign hi_ext    = {{(BUS_W-HI_W){hi_i[HI_W-1]}}, hi_i};
  assign rd_data_o = rd_sel_i ? hi_ext : lo_i;

  // status covers the full accumulator, not the selected half
  assign flag_z_o = ~(|hi_i) & ~(|lo_i);
  assign flag_n_o = hi_i[HI_W-1];
  assign flag_v_o = 1'b0;
  assign flag_c_o = 1'b0;

  always_comb begin
    flag_upd_o = '0;
    if (rd_i) begin
      flag_upd_o[FLG_Z] = 1'b1;
      flag_upd_o[FLG_N] = 1'b1;
      flag_upd_o[FLG_V] = 1'b1;
    end
    if (ld_i && !clr_i) begin
      flag_upd_o[FLG_V] = 1'b1;
      flag_upd_o[FLG_C] = 1'b1;
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
`timescale 1ns/1ps
module mac_acc_unit
  import mac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic             ld_sel_i,
  input  logic [BUS_W-1:0] ld_data_i,
  input  logic             acc_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic             rd_i,
  input  logic             rd_sel_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_v_o,
  output logic             flag_c_o,
  output logic [3:0]       flag_upd_o
);
  logic [ACC_W-1:0] prod;
  logic [HI_W-1:0]  hi_q;
  logic [LO_W-1:0]  lo_q;

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .prod_o (prod)
  );

  mac_acc_reg #(.HI_W(HI_W), .LO_W(LO_W), .BUS_W(BUS_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .ld_i      (ld_i),
    .ld_sel_i  (ld_sel_i),
    .ld_data_i (ld_data_i),
    .acc_i     (acc_i),
    .prod_i    (prod),
    .hi_o      (hi_q),
    .lo_o      (lo_q)
  );

  mac_rd_flags #(.HI_W(HI_W), .LO_W(LO_W), .BUS_W(BUS_W)) u_rd (
    .hi_i       (hi_q),
    .lo_i       (lo_q),
    .rd_i       (rd_i),
    .rd_sel_i   (rd_sel_i),
    .ld_i       (ld_i),
    .clr_i      (clr_i),
    .rd_data_o  (rd_data_o),
    .flag_z_o   (flag_z_o),
    .flag_n_o   (flag_n_o),
    .flag_v_o   (flag_v_o),
    .flag_c_o   (flag_c_o),
    .flag_upd_o (flag_upd_o)
  );
endmodule

// File: rtl/mac_acc_unit_chk.sv
`timescale 1ns/1ps
module mac_acc_unit_chk
  import mac_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             ld_i,
  input logic             ld_sel_i,
  input logic [BUS_W-1:0] ld_data_i,
  input logic             acc_i,
  input logic [OP_W-1:0]  op_a_i,
  input logic [OP_W-1:0]  op_b_i,
  input logic             rd_i,
  input logic             rd_sel_i,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             flag_z_o,
  input logic [3:0]       flag_upd_o,
  input logic [HI_W-1:0]  hi_q,
  input logic [LO_W-1:0]  lo_q
);
  logic signed [31:0] prod_chk;
  assign prod_chk = $signed(op_a_i) * $signed(op_b_i);

  a_r1_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && acc_i) |=>
      ({hi_q, lo_q} == $past({hi_q, lo_q}) + {{(ACC_W-32){$past(prod_chk[31])}}, $past(prod_chk)}));

  a_r3_load_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_i && ld_sel_i) |=>
      (hi_q == $past(ld_data_i[HI_W-1:0]) && lo_q == $past(lo_q)));

  a_r5_load_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_i && !ld_sel_i) |=>
      (lo_q == $past(ld_data_i) && hi_q == $past(hi_q)));

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (hi_q == '0 && lo_q == '0));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && !acc_i) |=> ($stable(hi_q) && $stable(lo_q)));

  a_r4_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |-> (rd_data_o[BUS_W-1:HI_W] == {(BUS_W-HI_W){rd_data_o[HI_W-1]}}));

  a_r7_zero_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_z_o |-> (rd_data_o == '0));

  a_r9_read_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (flag_upd_o[2:0] == 3'b111));
endmodule

bind mac_acc_unit mac_acc_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .ld_i       (ld_i),
  .ld_sel_i   (ld_sel_i),
  .ld_data_i  (ld_data_i),
  .acc_i      (acc_i),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .rd_i       (rd_i),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .flag_z_o   (flag_z_o),
  .flag_upd_o (flag_upd_o),
  .hi_q       (hi_q),
  .lo_q       (lo_q)
);

// File: tb/mac_acc_unit_tb.sv
`timescale 1ns/1ps
module mac_acc_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 0, ld_i = 0, ld_sel_i = 0, acc_i = 0, rd_i = 0, rd_sel_i = 0;
  logic [31:0] ld_data_i = '0;
  logic [15:0] op_a_i = '0, op_b_i = '0;
  logic [31:0] rd_data_o;
  logic        flag_z_o, flag_n_o, flag_v_o, flag_c_o;
  logic [3:0]  flag_upd_o;

  int checks = 0;
  int failures = 0;
  logic [41:0] mdl = '0;

  always #2.5 clk_i = ~clk_i;

  mac_acc_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // read both halves and flags, compare to model
  task automatic read_all(input string req);
    logic [31:0] exp_hi;
    exp_hi = {{22{mdl[41]}}, mdl[41:32]};
    @(negedge clk_i);
    rd_i = 1; rd_sel_i = 0; #1;
    chk({req, " lo"}, rd_data_o, mdl[31:0]);
    chk({req, " R7 z"}, 32'(flag_z_o), 32'(mdl == '0));
    chk({req, " R8 n"}, 32'(flag_n_o), 32'(mdl[41]));
    chk({req, " R9 v"}, 32'(flag_v_o), 32'd0);
    chk({req, " R9 mask"}, 32'(flag_upd_o), 32'h7);
    rd_sel_i = 1; #1;
    chk({req, " R4 hi"}, rd_data_o, exp_hi);
    chk({req, " R7 z hi"}, 32'(flag_z_o), 32'(mdl == '0));
    chk({req, " R8 n hi"}, 32'(flag_n_o), 32'(mdl[41]));
    rd_i = 0;
  endtask

  task automatic do_clear();
    @(negedge clk_i); clr_i = 1;
    @(negedge clk_i); clr_i = 0;
    mdl = '0;
  endtask

  task automatic do_load(input logic sel, input logic [31:0] d);
    @(negedge clk_i); ld_i = 1; ld_sel_i = sel; ld_data_i = d; #1;
    chk("R9 load mask", 32'(flag_upd_o), 32'hC);
    chk("R9 load c", 32'(flag_c_o), 32'd0);
    chk("R9 load v", 32'(flag_v_o), 32'd0);
    @(negedge clk_i); ld_i = 0;
    if (sel) mdl[41:32] = d[9:0]; else mdl[31:0] = d;
  endtask

  task automatic do_acc(input logic [15:0] a, input logic [15:0] b);
    int p;
    @(negedge clk_i); acc_i = 1; op_a_i = a; op_b_i = b;
    @(negedge clk_i); acc_i = 0;
    p = int'($signed(a)) * int'($signed(b));
    mdl = mdl + {{10{p[31]}}, p};
  endtask

  task automatic t_reset();
    read_all("R11 reset");
  endtask

  task automatic t_clear();
    do_load(0, 32'h1234_5678);
    do_clear();
    read_all("R6 clear");
  endtask

  task automatic t_load();
    do_load(0, 32'hA5A5_A5A5);
    read_all("R5 load lo");
    do_load(1, 32'hA5A5_A5A5);
    @(negedge clk_i); rd_sel_i = 1; #1;
    chk("R3 hi keeps 10 bits", rd_data_o, 32'h0000_01A5);
    read_all("R3 load hi");
  endtask

  task automatic t_products();
    do_clear(); do_acc(16'd2, 16'd2);
    read_all("R1 2x2");
    do_clear(); do_acc(16'hFFFE, 16'd2);
    read_all("R1 neg");
    @(negedge clk_i); rd_sel_i = 0; #1;
    chk("R1 -2x2 lo", rd_data_o, 32'hFFFF_FFFC);
    rd_sel_i = 1; #1;
    chk("R4 -2x2 hi", rd_data_o, 32'hFFFF_FFFF);
    do_clear(); do_acc(16'd0, 16'd0);
    read_all("R7 0x0");
  endtask

  task automatic t_carry();
    do_clear();
    for (int i = 0; i < 8; i++) do_acc(16'h7FFF, 16'h7FFF);
    @(negedge clk_i); rd_sel_i = 1; #1;
    chk("R2 hi after 8", rd_data_o, 32'h1);
    rd_sel_i = 0; #1;
    chk("R2 lo after 8", rd_data_o, 32'hFFF8_0008);
    read_all("R2 carry");
    do_load(1, 32'h1FF); do_load(0, 32'hFFFF_FFFF);
    do_acc(16'd1, 16'd1);
    @(negedge clk_i); rd_sel_i = 1; #1;
    chk("R2 into sign", rd_data_o, 32'hFFFF_FE00);
    read_all("R8 sign");
    do_load(1, 32'h3FF); do_load(0, 32'hFFFF_FFFF);
    do_acc(16'd1, 16'd1);
    read_all("R2 wrap");
  endtask

  task automatic t_priority();
    do_load(0, 32'h55);
    @(negedge clk_i);
    clr_i = 1; ld_i = 1; ld_sel_i = 0; ld_data_i = 32'h99; acc_i = 1;
    op_a_i = 16'd3; op_b_i = 16'd3;
    @(negedge clk_i); clr_i = 0; ld_i = 0; acc_i = 0;
    mdl = '0;
    read_all("R10 clr wins");
    @(negedge clk_i);
    ld_i = 1; ld_sel_i = 0; ld_data_i = 32'h40; acc_i = 1;
    @(negedge clk_i); ld_i = 0; acc_i = 0;
    mdl = 42'h40;
    read_all("R10 ld over acc");
  endtask

  initial begin
    #12 rst_ni = 1;
    t_reset();
    t_clear();
    t_load();
    t_products();
    t_carry();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule